// File: doc/BRIEF.md
# Dual-port 7:1 video lane serializer

This block turns parallel video pixel words into serial bit streams for ten data lanes arranged as two ports of five lanes. Each port word is 35 bits wide: three 10-bit colour components plus horizontal sync, vertical sync, data enable and two general-purpose control bits. Every lane sends seven bits per pixel period, so the bit rate is seven times the pixel rate. A sixth stream on its own output, the forwarded clock lane, repeats a fixed seven-bit pattern every period so that a receiver can find word boundaries.

The block runs on a bit clock at seven times the pixel rate. A phase strobe marks bit slot 0 of every pixel period. The pixel clock is an ordinary input that the block samples on the bit clock. Parallel words are captured on the sampled rising or falling edge of the pixel clock, whichever is selected. A captured word moves into a hold register and is loaded into the lane shift registers at a later strobe edge. In single-pixel mode only port X carries data. In dual-pixel mode port X carries the odd pixel and port Y carries the even pixel of each pair. Each port can be switched off on its own. A power-down input silences every lane and also gates the bit clock output low.

Mode, enable and power-down settings are plain input pins. They take effect at strobe edges. No logic depends on the pixel frequency: only the strobe and the sampled pixel-clock edges pace the block.

Top module: `video_lane_serializer`

## Requirements
- R1: In each pixel period every data lane sends 7 bits, most significant first. Lane k of a port (A=0 up to E=4) carries port word bits [7k+6:7k]. Bit 7k+6 is on the lane in the clock cycle after the strobe edge that loads the word, and each later clock cycle shows the next lower bit.
- R2: When not powered down, the forwarded clock lane sends the pattern 1100011 (left bit first) each period, with the same alignment as the data lanes.
- R3: Port X carries word_x in both modes. Port Y carries word_y when dual_mode=1. Word layout: bits 9:0 red, 19:10 green, 29:20 blue, 30 horizontal sync, 31 vertical sync, 32 data enable, 33 and 34 general-purpose control.
- R4: If dual_mode=0 at a strobe edge, all port Y lanes stay low for that period, whatever word_y holds.
- R5: With cap_fall=0, a word is captured at the clock edge where pclk is sampled 1 after being sampled 0. It is serialized in the period that starts at the first strobe edge two or more clock cycles after the capture.
- R6: With cap_fall=1, a word is captured at the clock edge where pclk is sampled 0 after being sampled 1. The same rule as R5 decides its period.
- R7: If port_x_en=0 at a strobe edge, all port X lanes stay low for that period. port_y_en does the same for port Y.
- R8: If power_down=1 at a strobe edge, every data lane and the clock lane stay low for that period. No words are captured while power_down=1.
- R9: During reset, and until the first strobe edge after reset is released, all lanes, the clock lane and bit_clk_o are low.
- R10: bit_clk_o follows clk. The exception is a period that starts with power_down=1: from the first falling clk edge of that period until the next strobe edge, bit_clk_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| bit_strobe | input | 1 | High in bit slot 0 of each pixel period |
| pclk | input | 1 | Pixel clock, sampled on clk |
| cap_fall | input | 1 | 0: capture on pclk rising edge, 1: capture on falling edge |
| dual_mode | input | 1 | 1: dual-pixel, port Y active |
| port_x_en | input | 1 | Port X enable |
| port_y_en | input | 1 | Port Y enable |
| power_down | input | 1 | Power-down request |
| word_x | input | 35 | Odd or single pixel word |
| word_y | input | 35 | Even pixel word |
| lane_x | output | 5 | Port X serial lanes, bit k is lane k |
| lane_y | output | 5 | Port Y serial lanes |
| fwd_clk_lane | output | 1 | Forwarded clock lane |
| bit_clk_o | output | 1 | Gated bit clock output |

## Verification
The hardest case to reach is a change of capture edge, or a return from power-down, in the middle of a word stream. There, one word can be overwritten in the hold register, or a stale word can be sent again, and the period a word lands in shifts by one. The stimulus flips the capture edge every two periods and puts a ten-period power-down inside dual-pixel traffic. The scoreboard tags every expected word with the period it should land in, worked out from the edge in use when it was driven. A later word that claims the same or an earlier period replaces the expected entry. Periods that no word claims are checked only for the values that cannot depend on data: disabled ports, single-pixel port Y and power-down.

// File: rtl/vlser_pkg.sv
package vlser_pkg;

    localparam int SER_BITS       = 7;
    localparam int LANES_PER_PORT = 5;

    // Forwarded clock lane word, sent left bit first.
    localparam logic [SER_BITS-1:0] FWD_CLK_PATTERN = 7'b1100011;

    typedef enum logic {
        CAP_RISE = 1'b0,
        CAP_FALL = 1'b1
    } cap_edge_e;

endpackage

// File: rtl/vlser_capture.sv
module vlser_capture
    import vlser_pkg::*;
#(
    parameter int WIDTH = 70
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pclk,
    input  logic             cap_fall,
    input  logic             halt,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] hold_o
);

    typedef struct packed {
        logic             pclk_seen;
        logic             taken;
        logic [WIDTH-1:0] cap;
        logic [WIDTH-1:0] hold;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       edge_rise;
    logic       edge_fall;
    logic       hit;

    always_comb begin
        st_d           = st_q;
        edge_rise      = pclk & ~st_q.pclk_seen;
        edge_fall      = ~pclk & st_q.pclk_seen;
        hit            = ((cap_edge_e'(cap_fall) == CAP_FALL) ? edge_fall : edge_rise) & ~halt;
        st_d.pclk_seen = pclk;
        st_d.taken     = hit;
        if (hit) begin
            st_d.cap = din;
        end
        if (st_q.taken) begin
            st_d.hold = st_q.cap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.hold;

    // A capture is never taken while halted
    AST_NO_CAPTURE_HALTED: assert property (@(posedge clk) disable iff (rst)
        halt |=> !st_q.taken) else $error("capture during halt"); // R8

endmodule

// File: rtl/vlser_lanes.sv
module vlser_lanes #(
    parameter int LANES = 5,
    parameter int BITS  = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  run,
    input  logic [LANES*BITS-1:0] din,
    output logic [LANES-1:0]      lane_o
);

    typedef struct packed {
        logic [LANES-1:0][BITS-1:0] sh;
    } ser_state_t;

    ser_state_t       st_d, st_q;
    logic [LANES-1:0] din_msb;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < LANES; k++) begin
            din_msb[k] = din[k*BITS + BITS - 1];
            if (load) begin
                st_d.sh[k] = din[k*BITS +: BITS];
            end else if (run) begin
                st_d.sh[k] = {st_q.sh[k][BITS-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_o[k] = st_q.sh[k][BITS-1];
    end

    // The top bit of each lane slice leads the lane after a load
    AST_LOAD_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
        load |=> (lane_o == $past(din_msb))) else $error("lane lead bit wrong"); // R1

endmodule

// File: rtl/video_lane_serializer.sv
module video_lane_serializer
    import vlser_pkg::*;
#(
    parameter int LANES = LANES_PER_PORT,
    parameter int BITS  = SER_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_strobe,
    input  logic                  pclk,
    input  logic                  cap_fall,
    input  logic                  dual_mode,
    input  logic                  port_x_en,
    input  logic                  port_y_en,
    input  logic                  power_down,
    input  logic [LANES*BITS-1:0] word_x,
    input  logic [LANES*BITS-1:0] word_y,
    output logic [LANES-1:0]      lane_x,
    output logic [LANES-1:0]      lane_y,
    output logic                  fwd_clk_lane,
    output logic                  bit_clk_o
);

    localparam int PW     = LANES * BITS;
    localparam int NPORTS = 2;

    typedef struct packed {
        logic pd_frame;
    } top_state_t;

    top_state_t                   st_d, st_q;
    logic [NPORTS*PW-1:0]         held;
    logic [NPORTS-1:0][PW-1:0]    port_load;
    logic [NPORTS-1:0][LANES-1:0] port_lanes;
    logic [NPORTS-1:0]            port_on;
    logic [BITS-1:0]              clk_load;
    logic                         shift_run;
    logic                         gate_q;

    vlser_capture #(
        .WIDTH (NPORTS*PW)
    ) u_capture (
        .clk      (clk),
        .rst      (rst),
        .pclk     (pclk),
        .cap_fall (cap_fall),
        .halt     (power_down),
        .din      ({word_y, word_x}),
        .hold_o   (held)
    );

    always_comb begin
        st_d = st_q;
        if (bit_strobe) begin
            st_d.pd_frame = power_down;
        end
        shift_run  = ~st_q.pd_frame;
        port_on[0] = port_x_en & ~power_down;
        port_on[1] = port_y_en & dual_mode & ~power_down;
        for (int p = 0; p < NPORTS; p++) begin
            port_load[p] = port_on[p] ? held[p*PW +: PW] : '0;
        end
        clk_load = power_down ? '0 : FWD_CLK_PATTERN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{pd_frame: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        vlser_lanes #(
            .LANES (LANES),
            .BITS  (BITS)
        ) u_lanes (
            .clk    (clk),
            .rst    (rst),
            .load   (bit_strobe),
            .run    (shift_run),
            .din    (port_load[p]),
            .lane_o (port_lanes[p])
        );
    end

    vlser_lanes #(
        .LANES (1),
        .BITS  (BITS)
    ) u_clk_lane (
        .clk    (clk),
        .rst    (rst),
        .load   (bit_strobe),
        .run    (shift_run),
        .din    (clk_load),
        .lane_o (fwd_clk_lane)
    );

    assign lane_x = port_lanes[0];
    assign lane_y = port_lanes[1];

    // Gate changes only while clk is low, so no pulse is ever cut short
    always_ff @(negedge clk) begin
        gate_q <= ~st_q.pd_frame;
    end

    assign bit_clk_o = clk & gate_q;

    AST_PD_ALL_LOW: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe && power_down) |=> (lane_x == '0 && lane_y == '0 && !fwd_clk_lane))
        else $error("lanes active in power-down"); // R8

    AST_SINGLE_Y_LOW: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe && !dual_mode) |=> (lane_y == '0))
        else $error("port Y active in single mode"); // R4

    AST_X_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe && !port_x_en) |=> (lane_x == '0))
        else $error("disabled port X active"); // R7

    AST_CLK_LANE_LEAD: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe && !power_down) |=> fwd_clk_lane)
        else $error("clock lane lead bit low"); // R2

endmodule

// File: tb/sim_video_lane_serializer.sv
module sim_video_lane_serializer;

    localparam int LN = 5;
    localparam int SB = 7;
    localparam int PW = LN * SB;
    localparam int LAST_FRAME = 140;
    localparam logic [SB-1:0] PAT = 7'b1100011;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe = 1'b1;
    logic          pclk = 1'b1;
    logic          cap_fall = 1'b0;
    logic          dual = 1'b0;
    logic          enx = 1'b1;
    logic          eny = 1'b1;
    logic          pd = 1'b0;
    logic [PW-1:0] wx = '0;
    logic [PW-1:0] wy = '0;
    logic [LN-1:0] lx, ly;
    logic          ckl, bclk;

    always #5 clk = ~clk;

    video_lane_serializer #(.LANES(LN), .BITS(SB)) u0 (
        .clk(clk), .rst(rst), .bit_strobe(strobe), .pclk(pclk), .cap_fall(cap_fall),
        .dual_mode(dual), .port_x_en(enx), .port_y_en(eny), .power_down(pd),
        .word_x(wx), .word_y(wy), .lane_x(lx), .lane_y(ly),
        .fwd_clk_lane(ckl), .bit_clk_o(bclk)
    );

    typedef struct {
        int            idx;
        logic          fall;
        logic [PW-1:0] wx;
        logic [PW-1:0] wy;
    } exp_t;

    exp_t          sb_q[$];
    int            checks = 0;
    int            fails = 0;
    int            ph = 0;
    int            fr = 0;
    bit            done = 1'b0;
    logic          cfg_pd[0:255];
    logic          cfg_dual[0:255];
    logic          cfg_enx[0:255];
    logic          cfg_eny[0:255];
    logic [31:0]   rng = 32'h1234_5679;
    logic [PW-1:0] rx_x = '0;
    logic [PW-1:0] rx_y = '0;
    logic [SB-1:0] rx_ck = '0;

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] v = s;
        v = v ^ (v << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    task automatic check_val(input string tag, input string what,
                             input logic [PW-1:0] got, input logic [PW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s frame %0d %s got %h expected %h", tag, fr, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic make_word(input int f, output logic [PW-1:0] w);
        if (f % 11 == 5) begin
            w = '1;
        end else if (f % 11 == 8) begin
            w = '0;
        end else begin
            rng = step(rng);
            w[31:0] = rng;
            rng = step(rng);
            w[PW-1:32] = rng[PW-33:0];
        end
    endtask

    task automatic drive_frame(input int f);
        exp_t e;
        int   t;
        if (f == 2) rst = 1'b0;
        dual     = (f >= 20 && f < 120);
        cap_fall = (f >= 40 && f < 60) || (f >= 60 && f < 70 && ((f / 2) % 2 == 1));
        enx      = !(f >= 70 && f < 80);
        eny      = !(f >= 80 && f < 90) && !(f >= 125);
        pd       = (f >= 90 && f < 100);
        make_word(f, wx);
        make_word(f + 1000, wy);
        cfg_pd[f]   = pd;
        cfg_dual[f] = dual;
        cfg_enx[f]  = enx;
        cfg_eny[f]  = eny;
        if (f >= 2 && !pd) begin
            t = cap_fall ? f + 1 : f + 2;
            // a newer word aimed at the same or an earlier period overwrites the hold register
            while (sb_q.size() > 0 && sb_q[$].idx >= t) void'(sb_q.pop_back());
            e.idx = t; e.fall = cap_fall; e.wx = wx; e.wy = wy;
            sb_q.push_back(e);
        end
    endtask

    task automatic eval_frame(input int g);
        exp_t  e;
        bit    has;
        bit    p;
        string et;
        if (g < 3) begin
            check_val("R9", "reset lanes X", rx_x, '0);
            check_val("R9", "reset lanes Y", rx_y, '0);
            check_val("R9", "reset clock lane", PW'(rx_ck), '0);
            return;
        end
        p = cfg_pd[g-1];
        while (sb_q.size() > 0 && sb_q[0].idx < g) void'(sb_q.pop_front());
        has = (sb_q.size() > 0 && sb_q[0].idx == g);
        if (has) e = sb_q.pop_front();
        et = (has && e.fall) ? "R6" : "R5";
        check_val(p ? "R8" : "R2", "clock lane", PW'(rx_ck), p ? '0 : PW'(PAT));
        if (p) begin
            check_val("R8", "port X", rx_x, '0);
            check_val("R8", "port Y", rx_y, '0);
            return;
        end
        if (!cfg_enx[g-1]) check_val("R7", "port X off", rx_x, '0);
        else if (has) check_val({"R1 R3 ", et}, "port X", rx_x, e.wx);
        if (!cfg_dual[g-1]) check_val("R4", "port Y single", rx_y, '0);
        else if (!cfg_eny[g-1]) check_val("R7", "port Y off", rx_y, '0);
        else if (has) check_val({"R3 ", et}, "port Y", rx_y, e.wy);
    endtask

    // monitor, then driver, then slot advance; all on the falling edge
    always @(negedge clk) begin
        if (!done) begin
            for (int k = 0; k < LN; k++) begin
                rx_x[k*SB + (SB - 1 - ph)] = lx[k];
                rx_y[k*SB + (SB - 1 - ph)] = ly[k];
            end
            rx_ck[SB - 1 - ph] = ckl;
            if (ph == SB - 1) eval_frame(fr);
            if (ph == 0) begin
                if (fr == LAST_FRAME) finish_run();
                drive_frame(fr);
            end
            ph = (ph == SB - 1) ? 0 : ph + 1;
            if (ph == 0) fr++;
            strobe = (ph == 0);
            pclk   = (ph < 4);
        end
    end

    // bit clock output, sampled just after a rising edge mid-period
    always @(posedge clk) begin
        #1;
        if (!done && ph == 3) begin
            if (fr < 3) check_val("R9", "bit clock in reset", PW'(bclk), '0);
            else check_val("R10", "bit clock", PW'(bclk), PW'(!cfg_pd[fr-1]));
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            cfg_pd[i] = 1'b0; cfg_dual[i] = 1'b0; cfg_enx[i] = 1'b1; cfg_eny[i] = 1'b1;
        end
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog expired got running expected finished");
            finish_run();
        end
    end

endmodule